// File: doc/BRIEF.md
# Floating-Point Reservation Station Pool

This block is the waiting area of a dynamically scheduled floating-point pipeline. It holds five stations. Three feed an add/subtract unit and two feed a multiply/divide unit. Each issued instruction brings an operation code, an immediate field and two source operands. A source is either a value that is already valid or a tag naming the station or load buffer that will produce it. The block returns the tag of the station it allocated, and that tag is written into the register status table outside this block.

A single shared result bus carries a tag and a value. Every station that is waiting on that tag copies the value in. A station with both values in hand presents itself to its functional unit. Within a class the lowest-numbered ready station goes first. A station is released when a result carrying its own tag appears on the bus. Stations are not read through a register file. Their operands are filled only by matching tags on the bus. The functional units, register file and fetch logic sit outside and are seen only as ports.

Top module: `fp_station_pool`

## Requirements
- R1: After reset every station is free, `add_room` and `mul_room` are 1, and `add_go` and `mul_go` are 0.
- R2: Station tags are 1, 2, 3 for the adder stations and 4, 5 for the multiplier stations. On `iss_valid` with room in the selected class (`iss_mul`=0 adder, 1 multiplier), `iss_tag` shows the tag of the lowest-numbered free station of that class, and the next edge loads that station.
- R3: When no station of the requested class is free, the class room flag is 0, `iss_tag` is 0 and the issue is ignored: no station changes.
- R4: A source tag of 0 means the value is valid. A station whose `qj` or `qk` tag is nonzero does not request dispatch, including while the result bus carries a different tag.
- R5: When `cdb_valid` is high and `cdb_tag` equals a station's pending source tag, that source takes `cdb_value` at the edge, and the station may request dispatch in the following cycle.
- R6: If the result bus carries the tag of a source being issued in the same cycle, the new station stores the bus value instead of the tag.
- R7: Per class, the lowest-numbered ready station is presented on the `*_go` outputs. It stays presented until the unit-ready input accepts it, and it is never presented again afterwards.
- R8: A busy station is freed at the edge where `cdb_valid` is high with its own tag, and it can be allocated again from the next cycle.
- R9: The two classes are independent: an adder and a multiplier dispatch can happen in the same cycle, and filling one class does not affect the other's room flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue request |
| iss_mul | input | 1 | Class select: 0 adder, 1 multiplier |
| iss_op | input | OP_W | Operation code |
| iss_qj | input | TAG_W | First source producer tag, 0 if value valid |
| iss_vj | input | DATA_W | First source value |
| iss_qk | input | TAG_W | Second source producer tag, 0 if value valid |
| iss_vk | input | DATA_W | Second source value |
| iss_imm | input | IMM_W | Address / immediate field |
| add_room | output | 1 | An adder station is free |
| mul_room | output | 1 | A multiplier station is free |
| iss_tag | output | TAG_W | Tag of the station being allocated, 0 if none |
| cdb_valid | input | 1 | Result bus carries a result |
| cdb_tag | input | TAG_W | Producer tag on the result bus |
| cdb_value | input | DATA_W | Result value |
| add_unit_ready | input | 1 | Adder accepts the presented operation |
| add_go | output | 1 | An adder station is ready |
| add_go_tag | output | TAG_W | Tag of the presented adder station |
| add_go_op | output | OP_W | Its operation |
| add_go_a | output | DATA_W | Its first operand |
| add_go_b | output | DATA_W | Its second operand |
| add_go_imm | output | IMM_W | Its immediate |
| mul_unit_ready | input | 1 | Multiplier accepts the presented operation |
| mul_go | output | 1 | A multiplier station is ready |
| mul_go_tag | output | TAG_W | Tag of the presented multiplier station |
| mul_go_op | output | OP_W | Its operation |
| mul_go_a | output | DATA_W | Its first operand |
| mul_go_b | output | DATA_W | Its second operand |
| mul_go_imm | output | IMM_W | Its immediate |

## Verification
A wrong busy or sent bit shows within one cycle as a room flag that disagrees with the count of stations issued and freed, or as a dispatch that repeats or never appears. A missed or misrouted bus capture leaves a station silent after its producer's tag has been broadcast. A wrong capture shows as a bad operand on the go outputs in the very next cycle. Because the operands pass through unchanged, the go values identify which station and which operand was corrupted.

// File: rtl/fp_station_pool.sv
module fp_station_pool #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4,
  parameter int OP_W   = 2,
  parameter int IMM_W  = 16,
  parameter int N_ADD  = 3,
  parameter int N_MUL  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic              iss_mul,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [TAG_W-1:0]  iss_qj,
  input  logic [DATA_W-1:0] iss_vj,
  input  logic [TAG_W-1:0]  iss_qk,
  input  logic [DATA_W-1:0] iss_vk,
  input  logic [IMM_W-1:0]  iss_imm,
  output logic              add_room,
  output logic              mul_room,
  output logic [TAG_W-1:0]  iss_tag,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_value,
  input  logic              add_unit_ready,
  output logic              add_go,
  output logic [TAG_W-1:0]  add_go_tag,
  output logic [OP_W-1:0]   add_go_op,
  output logic [DATA_W-1:0] add_go_a,
  output logic [DATA_W-1:0] add_go_b,
  output logic [IMM_W-1:0]  add_go_imm,
  input  logic              mul_unit_ready,
  output logic              mul_go,
  output logic [TAG_W-1:0]  mul_go_tag,
  output logic [OP_W-1:0]   mul_go_op,
  output logic [DATA_W-1:0] mul_go_a,
  output logic [DATA_W-1:0] mul_go_b,
  output logic [IMM_W-1:0]  mul_go_imm
);
  localparam int N_ST = N_ADD + N_MUL;
  localparam int IW   = $clog2(N_ST + 1);

  logic              busy  [N_ST];
  logic              sent  [N_ST];
  logic [OP_W-1:0]   op_q  [N_ST];
  logic [TAG_W-1:0]  qj    [N_ST];
  logic [TAG_W-1:0]  qk    [N_ST];
  logic [DATA_W-1:0] vj    [N_ST];
  logic [DATA_W-1:0] vk    [N_ST];
  logic [IMM_W-1:0]  imm_q [N_ST];
  logic              rdy   [N_ST];

  logic [IW-1:0] add_pick, mul_pick, add_sel, mul_sel, widx;
  logic          we, add_fire, mul_fire, cdb_frees_add;

  always_comb begin
    add_room = 1'b0; add_pick = '0; add_go = 1'b0; add_sel = '0;
    for (int i = N_ADD - 1; i >= 0; i--) begin
      if (!busy[i]) begin add_room = 1'b1; add_pick = IW'(i); end
      if (rdy[i])   begin add_go   = 1'b1; add_sel  = IW'(i); end
    end
    mul_room = 1'b0; mul_pick = '0; mul_go = 1'b0; mul_sel = '0;
    for (int i = N_ST - 1; i >= N_ADD; i--) begin
      if (!busy[i]) begin mul_room = 1'b1; mul_pick = IW'(i); end
      if (rdy[i])   begin mul_go   = 1'b1; mul_sel  = IW'(i); end
    end
    cdb_frees_add = 1'b0;
    for (int i = 0; i < N_ADD; i++)
      if (busy[i] && cdb_valid && cdb_tag == TAG_W'(i + 1)) cdb_frees_add = 1'b1;
  end

  assign we       = iss_valid && (iss_mul ? mul_room : add_room);
  assign widx     = iss_mul ? mul_pick : add_pick;
  assign iss_tag  = we ? TAG_W'(widx) + TAG_W'(1) : '0;
  assign add_fire = add_go && add_unit_ready;
  assign mul_fire = mul_go && mul_unit_ready;

  assign add_go_tag = TAG_W'(add_sel) + TAG_W'(1);
  assign add_go_op  = op_q[add_sel];
  assign add_go_a   = vj[add_sel];
  assign add_go_b   = vk[add_sel];
  assign add_go_imm = imm_q[add_sel];
  assign mul_go_tag = TAG_W'(mul_sel) + TAG_W'(1);
  assign mul_go_op  = op_q[mul_sel];
  assign mul_go_a   = vj[mul_sel];
  assign mul_go_b   = vk[mul_sel];
  assign mul_go_imm = imm_q[mul_sel];

  for (genvar s = 0; s < N_ST; s++) begin : g_st
    localparam logic [TAG_W-1:0] MY_TAG = TAG_W'(s + 1);
    logic fired;
    assign rdy[s] = busy[s] && !sent[s] && qj[s] == '0 && qk[s] == '0;
    assign fired  = (s < N_ADD) ? (add_fire && add_sel == IW'(s))
                                : (mul_fire && mul_sel == IW'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy[s] <= 1'b0; sent[s] <= 1'b0; op_q[s] <= '0; imm_q[s] <= '0;
        qj[s] <= '0; qk[s] <= '0; vj[s] <= '0; vk[s] <= '0;
      end else if (we && widx == IW'(s)) begin
        busy[s]  <= 1'b1;
        sent[s]  <= 1'b0;
        op_q[s]  <= iss_op;
        imm_q[s] <= iss_imm;
        if (iss_qj == '0) begin
          qj[s] <= '0; vj[s] <= iss_vj;
        end else if (cdb_valid && cdb_tag == iss_qj) begin
          qj[s] <= '0; vj[s] <= cdb_value;
        end else begin
          qj[s] <= iss_qj; vj[s] <= '0;
        end
        if (iss_qk == '0) begin
          qk[s] <= '0; vk[s] <= iss_vk;
        end else if (cdb_valid && cdb_tag == iss_qk) begin
          qk[s] <= '0; vk[s] <= cdb_value;
        end else begin
          qk[s] <= iss_qk; vk[s] <= '0;
        end
      end else if (busy[s]) begin
        if (cdb_valid && cdb_tag == MY_TAG) begin
          busy[s] <= 1'b0;
          sent[s] <= 1'b0;
        end else begin
          if (fired) sent[s] <= 1'b1;
          if (cdb_valid && qj[s] != '0 && cdb_tag == qj[s]) begin
            qj[s] <= '0; vj[s] <= cdb_value;
          end
          if (cdb_valid && qk[s] != '0 && cdb_tag == qk[s]) begin
            qk[s] <= '0; vk[s] <= cdb_value;
          end
        end
      end
    end
  end

  assert_issue_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_mul && add_room) |-> (iss_tag >= 1 && iss_tag <= N_ADD));

  assert_full_stays_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!add_room && !cdb_valid) |=> !add_room);

  assert_free_on_own_tag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cdb_frees_add |=> add_room);

  assert_add_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    add_fire |=> !(add_go && add_go_tag == $past(add_go_tag)));

  assert_mul_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mul_fire |=> !(mul_go && mul_go_tag == $past(mul_go_tag)));

  assert_mul_tag_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mul_go |-> (mul_go_tag > N_ADD && mul_go_tag <= N_ST));
endmodule

// File: tb/fp_station_pool_bench.sv
module fp_station_pool_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        iss_valid, iss_mul, cdb_valid, add_unit_ready, mul_unit_ready;
  logic [1:0]  iss_op;
  logic [3:0]  iss_qj, iss_qk, cdb_tag, iss_tag, add_go_tag, mul_go_tag;
  logic [31:0] iss_vj, iss_vk, cdb_value, add_go_a, add_go_b, mul_go_a, mul_go_b;
  logic [15:0] iss_imm, add_go_imm, mul_go_imm;
  logic [1:0]  add_go_op, mul_go_op;
  logic        add_room, mul_room, add_go, mul_go;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  fp_station_pool u_fp_station_pool (.*);

  // row: mul, op, vj, vk, imm, expected tag
  localparam logic [86:0] VEC [4] = '{
    {1'b0, 2'd1, 32'h0000_1111, 32'h0000_2222, 16'h00a0, 4'd1},
    {1'b1, 2'd2, 32'h3333_0000, 32'h4444_0000, 16'h00b1, 4'd4},
    {1'b0, 2'd3, 32'hdead_beef, 32'h0bad_f00d, 16'h1234, 4'd1},
    {1'b1, 2'd0, 32'h0000_0001, 32'hffff_ffff, 16'hffff, 4'd4}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic idle();
    iss_valid = 0; iss_mul = 0; iss_op = 0; iss_qj = 0; iss_qk = 0;
    iss_vj = 0; iss_vk = 0; iss_imm = 0; cdb_valid = 0; cdb_tag = 0; cdb_value = 0;
  endtask

  task automatic do_reset();
    idle(); add_unit_ready = 0; mul_unit_ready = 0; rst_n = 0;
    tick(); tick(); rst_n = 1; #1;
  endtask

  task automatic issue(input logic m, input logic [1:0] op, input logic [3:0] qj,
                       input logic [31:0] vj, input logic [3:0] qk, input logic [31:0] vk,
                       input logic [15:0] imm);
    iss_valid = 1; iss_mul = m; iss_op = op; iss_qj = qj; iss_vj = vj;
    iss_qk = qk; iss_vk = vk; iss_imm = imm; #1;
  endtask

  task automatic bcast(input logic [3:0] t, input logic [31:0] v);
    cdb_valid = 1; cdb_tag = t; cdb_value = v; #1;
  endtask

  initial begin
    #(200000 * 5);
    fails++; tests++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk("R1 add_room", add_room, 1); chk("R1 mul_room", mul_room, 1);
    chk("R1 add_go", add_go, 0);     chk("R1 mul_go", mul_go, 0);

    for (int r = 0; r < 4; r++) begin
      logic m; logic [1:0] op; logic [31:0] a, b; logic [15:0] im; logic [3:0] t;
      {m, op, a, b, im, t} = VEC[r];
      issue(m, op, 0, a, 0, b, im);
      chk("R2 iss_tag", iss_tag, t);
      tick(); idle(); #1;
      chk("R2 go", m ? mul_go : add_go, 1);
      chk("R2 go_tag", m ? mul_go_tag : add_go_tag, t);
      chk("R2 go_op", m ? mul_go_op : add_go_op, op);
      chk("R2 go_a", m ? mul_go_a : add_go_a, a);
      chk("R2 go_b", m ? mul_go_b : add_go_b, b);
      chk("R2 go_imm", m ? mul_go_imm : add_go_imm, im);
      add_unit_ready = 1; mul_unit_ready = 1;
      tick(); add_unit_ready = 0; mul_unit_ready = 0; #1;
      chk("R7 no repeat", m ? mul_go : add_go, 0);
      bcast(t, 0); tick(); idle(); #1;
      chk("R8 room", m ? mul_room : add_room, 1);
    end

    do_reset();
    for (int k = 0; k < 3; k++) begin
      issue(0, 2'(k), 4'd6, 0, 0, 32'(10 * (k + 1)), 0);
      chk("R2 lowest free", iss_tag, 4'(k + 1));
      tick();
    end
    idle(); #1;
    chk("R3 add_room", add_room, 0);
    chk("R9 mul_room", mul_room, 1);
    issue(0, 3, 0, 99, 0, 99, 0);
    chk("R3 iss_tag", iss_tag, 0);
    tick(); idle(); #1;
    chk("R3 R4 no go", add_go, 0);
    bcast(4'd9, 32'h5); tick(); idle(); #1;
    chk("R4 other tag", add_go, 0);
    bcast(4'd6, 32'h77); tick(); idle(); #1;
    chk("R5 go", add_go, 1); chk("R7 lowest", add_go_tag, 1);
    chk("R5 a", add_go_a, 32'h77); chk("R5 b", add_go_b, 10);
    tick();
    chk("R7 held", add_go_tag, 1);
    add_unit_ready = 1; tick(); #1;
    chk("R7 next", add_go_tag, 2); chk("R5 b2", add_go_b, 20);
    tick(); #1;
    chk("R7 third", add_go_tag, 3); chk("R3 op kept", add_go_op, 2);
    tick(); #1;
    chk("R7 drained", add_go, 0);
    add_unit_ready = 0;
    bcast(4'd2, 0);
    chk("R8 before", add_room, 0);
    tick(); idle(); #1;
    chk("R8 freed", add_room, 1);
    issue(0, 0, 0, 1, 0, 1, 0);
    chk("R8 R2 reuse", iss_tag, 2);
    idle();

    do_reset();
    issue(1, 1, 4'd7, 0, 0, 3, 0);
    bcast(4'd7, 32'h55);
    chk("R6 tag", iss_tag, 4);
    tick(); idle(); #1;
    chk("R6 go", mul_go, 1); chk("R6 a", mul_go_a, 32'h55); chk("R6 b", mul_go_b, 3);

    do_reset();
    issue(1, 0, 0, 5, 4'd8, 0, 0);
    tick(); idle(); #1;
    chk("R4 qk wait", mul_go, 0);
    bcast(4'd9, 1); tick(); idle(); #1;
    chk("R4 qk other", mul_go, 0);
    bcast(4'd8, 32'h21); tick(); idle(); #1;
    chk("R5 qk", mul_go, 1); chk("R5 qk b", mul_go_b, 32'h21); chk("R5 qk a", mul_go_a, 5);

    do_reset();
    issue(0, 1, 0, 1, 0, 2, 0); tick();
    issue(1, 2, 0, 3, 0, 4, 0); tick(); idle(); #1;
    chk("R9 add_go", add_go, 1); chk("R9 mul_go", mul_go, 1);
    chk("R9 add tag", add_go_tag, 1); chk("R9 mul tag", mul_go_tag, 4);
    chk("R9 mul a", mul_go_a, 3);
    add_unit_ready = 1; mul_unit_ready = 1; tick(); #1;
    chk("R9 both sent", {add_go, mul_go}, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule